// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Router

This block collects up to thirty-two interrupt request lines and folds them into two level-sensitive requests for a processor: an ordinary request and a critical request. Software configures it through a small register port of nine word-wide registers. It chooses, per source, whether the line is captured on its rising edge or followed as a level, whether the source is allowed through at all, and which of the two outputs it drives.

For the critical path, the block also produces a ready-made handler address. Software programs a base address and a scan direction. The block then scans the pending critical sources from the chosen end and adds 512 bytes per priority step to the base. A source that arrives as a level keeps its pending bit alive even after software acknowledges it, so an acknowledge cannot lose a line that is still active.

Both outputs and the vector are registered. They reflect the register state one clock after that state changes. Register reads are combinational from the current state.

Top module: `irq_router`

## Requirements
- R1: Register offsets are: 0 status, 1 status-set, 2 enable, 3 critical select, 4 polarity (stored and read back only), 5 trigger mode, 6 masked status, 7 vector, 8 vector config. Offsets 0 and 1 both read the status. Offset 6 reads status AND enable. Offsets 9 to 15 read as 0.
- R2: Input line n drives status bit (31 − n).
- R3: When a source's trigger bit is 1 (edge mode), a rising input sets its status bit. The bit stays set after the input falls, and only a software clear removes it, even while the input is still high.
- R4: When a source's trigger bit is 0 (level mode), any change of its input copies the new input value into both its status bit and its internal hold bit.
- R5: A write to offset 0 clears every status bit written as 1 and then ORs the hold bits back in, so an active level source stays pending. An input event in the same cycle is applied after the write.
- R6: A write to offset 1 ORs the written word into the status.
- R7: The normal output equals, one clock later, whether status AND enable AND NOT critical is nonzero.
- R8: The critical output equals, one clock later, whether status AND enable AND critical is nonzero.
- R9: With vector config bit 0 at 0, the vector is the config value with bits 1:0 cleared, plus 512 × k, where k is the index of the lowest set critical-pending bit. The vector is registered one clock after the state it is computed from.
- R10: With vector config bit 0 at 1, k is 31 minus the index of the highest set critical-pending bit.
- R11: The vector reads 0 whenever no critical source is pending.
- R12: Writes to offsets 6 and 7 change nothing. A write to offset 8 stores the value with bit 1 forced to 0.
- R13: While reset is high, all registers, both outputs and the vector return to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request lines, line n maps to status bit 31−n |
| reg_addr | input | 4 | Register offset for read and write |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_norm | output | 1 | Registered normal interrupt request |
| irq_crit | output | 1 | Registered critical interrupt request |

## Verification
The hardest state to reach from the ports is a level-mode pending bit that differs from its input. Examples are a bit raised through the status-set register while its line is low, and a held bit that survives an acknowledge. Those states only arise from a particular order of input changes and register writes. The directed part of the stimulus builds these orders step by step: it raises a line, acknowledges it while the line is still high, then drops the line, and it sets level bits from software on quiet lines. A long random phase follows, in which line toggles, trigger-mode changes and acknowledges collide in the same cycle. A behavioural reference model is compared against the design on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC        = 32;
    localparam int REG_AW      = 4;
    localparam int STRIDE_LOG2 = 9;

    typedef enum logic [REG_AW-1:0] {
        OFS_STAT = 4'd0,
        OFS_SET  = 4'd1,
        OFS_EN   = 4'd2,
        OFS_CRIT = 4'd3,
        OFS_POL  = 4'd4,
        OFS_TRIG = 4'd5,
        OFS_MSK  = 4'd6,
        OFS_VEC  = 4'd7,
        OFS_VCFG = 4'd8
    } reg_ofs_e;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] crit;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
        logic [NSRC-1:0] vcfg;
    } cfg_regs_t;

    typedef struct packed {
        logic            norm;
        logic            crit;
        logic [NSRC-1:0] vec;
    } out_regs_t;

    // value stored into the vector configuration register
    function automatic logic [NSRC-1:0] vcfg_store(input logic [NSRC-1:0] wd);
        return wd & ~(NSRC'(2));
    endfunction

endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int N = irqc_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] trig,
    input  logic         sw_clr,
    input  logic         sw_set,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);
    logic [N-1:0] st_q, hold_q, prev_q;
    logic [N-1:0] sw_val, rise, lvl_upd, st_d, hold_d;

    always_comb begin
        sw_val = st_q;
        if (sw_clr) sw_val = (st_q & ~wdata) | hold_q;
        else if (sw_set) sw_val = st_q | wdata;
        rise    = src & ~prev_q & trig;
        lvl_upd = (src ^ prev_q) & ~trig;
        st_d    = ((sw_val | rise) & ~lvl_upd) | (src & lvl_upd);
        hold_d  = (hold_q & ~lvl_upd) | (src & lvl_upd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            hold_q <= '0;
            prev_q <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            prev_q <= src;
        end
    end

    assign status = st_q;

    // R3: an edge-mode rising line is pending on the next clock
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q & $past(rise)) == $past(rise)));

    // R4: a level-mode line that changed is mirrored into status
    a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q & $past(lvl_upd)) == ($past(src) & $past(lvl_upd))));

    // R6: a set-status write leaves the written bits pending unless a level line just fell
    a_r6_set_or: assert property (@(posedge clk) disable iff (rst)
        (sw_set && !sw_clr) |=> ((st_q & $past(wdata) & ~$past(lvl_upd)) == ($past(wdata) & ~$past(lvl_upd))));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N           = irqc_pkg::NSRC,
    parameter int STRIDE_LOG2 = irqc_pkg::STRIDE_LOG2
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] cfg,
    output logic [N-1:0] vec
);
    localparam int KW = $clog2(N);

    logic [KW-1:0] k_up, k_dn, k_sel;
    logic [N-1:0]  base;

    always_comb begin
        k_up = '0;
        k_dn = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) k_up = KW'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (pend[i]) k_dn = KW'(N - 1 - i);
        end
        k_sel = cfg[0] ? k_dn : k_up;
        base  = {cfg[N-1:2], 2'b00};
        vec   = (pend == '0) ? '0 : base + (N'(k_sel) << STRIDE_LOG2);
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irqc_pkg::*;
#(
    parameter int N = irqc_pkg::NSRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_in,
    input  logic [3:0]    reg_addr,
    input  logic          reg_we,
    input  logic [N-1:0]  reg_wdata,
    output logic [N-1:0]  reg_rdata,
    output logic          irq_norm,
    output logic          irq_crit
);
    cfg_regs_t    cfg_q;
    out_regs_t    out_q;
    logic [N-1:0] src, status, crit_pend, norm_pend, vec_c;
    logic         wr_clr, wr_set;

    // line n lands on status bit N-1-n
    for (genvar g = 0; g < N; g++) begin : g_rev
        assign src[g] = irq_in[N-1-g];
    end

    assign wr_clr = reg_we && (reg_addr == OFS_STAT);
    assign wr_set = reg_we && (reg_addr == OFS_SET);

    irqc_status #(.N(N)) u_status (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .trig   (cfg_q.trig),
        .sw_clr (wr_clr),
        .sw_set (wr_set),
        .wdata  (reg_wdata),
        .status (status)
    );

    assign crit_pend = status & cfg_q.en & cfg_q.crit;
    assign norm_pend = status & cfg_q.en & ~cfg_q.crit;

    irqc_prio #(.N(N), .STRIDE_LOG2(STRIDE_LOG2)) u_prio (
        .pend (crit_pend),
        .cfg  (cfg_q.vcfg),
        .vec  (vec_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_EN:   cfg_q.en   <= reg_wdata;
                OFS_CRIT: cfg_q.crit <= reg_wdata;
                OFS_POL:  cfg_q.pol  <= reg_wdata;
                OFS_TRIG: cfg_q.trig <= reg_wdata;
                OFS_VCFG: cfg_q.vcfg <= vcfg_store(reg_wdata);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.norm <= |norm_pend;
            out_q.crit <= |crit_pend;
            out_q.vec  <= vec_c;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_STAT, OFS_SET: reg_rdata = status;
            OFS_EN:            reg_rdata = cfg_q.en;
            OFS_CRIT:          reg_rdata = cfg_q.crit;
            OFS_POL:           reg_rdata = cfg_q.pol;
            OFS_TRIG:          reg_rdata = cfg_q.trig;
            OFS_MSK:           reg_rdata = status & cfg_q.en;
            OFS_VEC:           reg_rdata = out_q.vec;
            OFS_VCFG:          reg_rdata = cfg_q.vcfg;
            default:           reg_rdata = '0;
        endcase
    end

    assign irq_norm = out_q.norm;
    assign irq_crit = out_q.crit;

    // R7: normal output follows the unmasked non-critical pending set a clock later
    a_r7_norm_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_norm == $past(|(status & cfg_q.en & ~cfg_q.crit))));

    // R8: critical output follows the critical pending set a clock later
    a_r8_crit_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_crit == $past(|(status & cfg_q.en & cfg_q.crit))));

    // R11: no critical request means a zero vector
    a_r11_vec_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_crit |-> (out_q.vec == '0));

    // R12: the stored vector config never holds bit 1
    a_r12_vcfg_bit1: assert property (@(posedge clk) disable iff (rst)
        reg_we && (reg_addr == OFS_VCFG) |=> (cfg_q.vcfg[1] == 1'b0));

    // R13: reset empties the outputs and the configuration
    a_r13_reset_clear: assert property (@(posedge clk)
        rst |=> (!irq_norm && !irq_crit && (cfg_q == '0) && (status == '0)));

endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_norm, irq_crit;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_st, m_en, m_cr, m_pol, m_tr, m_cfg, m_hold, m_prev, m_vec;
    bit          m_norm, m_crit;

    function automatic logic [31:0] ref_vec(input logic [31:0] cp, input logic [31:0] cfg);
        int k = -1;
        if (cp == 0) return 32'h0;
        if (!cfg[0]) begin
            for (int i = 0; i < 32; i++) if (k < 0 && cp[i]) k = i;
        end else begin
            for (int i = 31; i >= 0; i--) if (k < 0 && cp[i]) k = 31 - i;
        end
        return (cfg & 32'hFFFF_FFFC) + 32'(k * 512);
    endfunction

    function automatic logic [31:0] ref_read(input logic [3:0] a);
        case (a)
            0, 1: return m_st;
            2: return m_en;
            3: return m_cr;
            4: return m_pol;
            5: return m_tr;
            6: return m_st & m_en;
            7: return m_vec;
            8: return m_cfg;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        case (a)
            0: return "R5";
            1: return "R6";
            7: return "R9";
            8: return "R12";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] s, h, inr, cp;
        if (rst) begin
            m_st = 0; m_en = 0; m_cr = 0; m_pol = 0; m_tr = 0; m_cfg = 0;
            m_hold = 0; m_prev = 0; m_vec = 0; m_norm = 0; m_crit = 0;
        end else begin
            cp     = m_st & m_en & m_cr;
            m_norm = |(m_st & m_en & ~m_cr);
            m_crit = |cp;
            m_vec  = ref_vec(cp, m_cfg);
            for (int j = 0; j < 32; j++) inr[j] = irq_in[31-j];
            s = m_st;
            h = m_hold;
            if (reg_we && reg_addr == 0) s = (s & ~reg_wdata) | m_hold;
            if (reg_we && reg_addr == 1) s = s | reg_wdata;
            for (int j = 0; j < 32; j++) begin
                if (m_tr[j]) begin
                    if (inr[j] && !m_prev[j]) s[j] = 1'b1;
                end else if (inr[j] != m_prev[j]) begin
                    s[j] = inr[j];
                    h[j] = inr[j];
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    2: m_en  = reg_wdata;
                    3: m_cr  = reg_wdata;
                    4: m_pol = reg_wdata;
                    5: m_tr  = reg_wdata;
                    8: m_cfg = reg_wdata & 32'hFFFF_FFFD;
                    default: ;
                endcase
            end
            m_st = s; m_hold = h; m_prev = inr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R7 normal output", {31'b0, irq_norm}, {31'b0, m_norm});
            chk("R8 critical output", {31'b0, irq_crit}, {31'b0, m_crit});
            chk({read_tag(reg_addr), " read data"}, reg_rdata, ref_read(reg_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13: everything zero after reset
        for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R13 reset value");
        chk("R13 outputs after reset", {30'b0, irq_norm, irq_crit}, 32'h0);

        // R2, R4: level line 0 lands on bit 31
        wr(2, 32'hFFFF_FFFF);
        @(negedge clk); irq_in[0] = 1'b1;
        settle();
        rd(0, 32'h8000_0000, "R2 line 0 to bit 31");
        rd(0, 32'h8000_0000, "R4 level follows input");
        chk("R7 normal raised", {31'b0, irq_norm}, 32'h1);

        // R5: acknowledge while the level line is still high keeps it
        wr(0, 32'h8000_0000);
        settle();
        rd(0, 32'h8000_0000, "R5 hold reasserts");
        @(negedge clk); irq_in[0] = 1'b0;
        settle();
        rd(0, 32'h0, "R4 level drop clears");
        chk("R7 normal lowered", {31'b0, irq_norm}, 32'h0);

        // R3: edge source on line 5 (bit 26)
        wr(5, 32'h0400_0000);
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); irq_in[5] = 1'b0;
        settle();
        rd(0, 32'h0400_0000, "R3 edge latched");
        @(negedge clk); irq_in[5] = 1'b1;
        settle();
        wr(0, 32'h0400_0000);
        settle();
        rd(0, 32'h0, "R3 clear while line high");
        @(negedge clk); irq_in[5] = 1'b0;

        // R6: set-status on a quiet level line persists
        wr(1, 32'h0000_0010);
        settle();
        rd(1, 32'h0000_0010, "R6 set-status OR");
        wr(0, 32'h0000_0010);
        settle();
        rd(0, 32'h0, "R5 software clear");

        // R9, R12: upward scan, bit 1 of config dropped
        wr(3, 32'h0000_0F00);
        wr(8, 32'h0000_1002);
        rd(8, 32'h0000_1000, "R12 config bit1 forced low");
        wr(1, 32'h0000_0900);
        settle();
        rd(7, 32'h0000_2000, "R9 upward vector");
        chk("R8 critical raised", {31'b0, irq_crit}, 32'h1);
        chk("R7 normal stays low", {31'b0, irq_norm}, 32'h0);

        // R10: downward scan, highest pending bit 11 gives k=20
        wr(8, 32'h0000_1001);
        settle();
        rd(7, 32'h0000_3800, "R10 downward vector");

        // R12: writes to masked status and vector are ignored
        wr(6, 32'hFFFF_FFFF);
        wr(7, 32'h1234_5678);
        settle();
        rd(0, 32'h0000_0900, "R12 masked write ignored");
        rd(7, 32'h0000_3800, "R12 vector write ignored");
        rd(6, 32'h0000_0900, "R1 masked status");

        // R11: nothing critical pending gives zero vector
        wr(0, 32'h0000_0900);
        settle();
        rd(7, 32'h0, "R11 vector zero");
        chk("R8 critical lowered", {31'b0, irq_crit}, 32'h0);

        // R1: polarity storage and unused offsets
        wr(4, 32'h0000_A5A5);
        rd(4, 32'h0000_A5A5, "R1 polarity readback");
        rd(9, 32'h0, "R1 unused offset 9");
        rd(15, 32'h0, "R1 unused offset 15");

        // random collisions of lines and register writes
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            reg_we    = ($urandom_range(0, 3) == 0);
            reg_addr  = 4'($urandom_range(0, 15));
            reg_wdata = $urandom();
            if ($urandom_range(0, 1) == 0) irq_in = irq_in ^ (32'h1 << $urandom_range(0, 31));
        end
        @(negedge clk); reg_we = 1'b0;

        // R13: reset from a busy state
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        @(negedge clk); rst = 1'b1; irq_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(0, 32'h0, "R13 status after reset");
        rd(2, 32'h0, "R13 enable after reset");
        chk("R13 outputs after reset", {30'b0, irq_norm, irq_crit}, 32'h0);

        settle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule